// File: doc/BRIEF.md
# Serial Panel Register Writer

This block is a write-only, three-wire serial master that a display controller's configuration path uses to program a panel. It uses an active-low select, a clock and a data line. A client hands it commands over a valid/ready interface. Each command carries a kind, a 16-bit word and a "last" flag. The block wraps each command into a serial frame. The frame opens with a start byte that tells the panel whether the payload is a register index or a data value. The payload follows, most significant bit first.

For bulk pixel fills, a pixel command opens a burst. The data start byte is sent once. After that, every further accepted command adds one 16-bit word while select stays low, until a command marked last closes the frame. A programmable half-bit period, with a floor set at build time, paces the clock. A guard gap with select high separates frames. Between transfers all three lines rest high.

Top module: `panel_wr_engine`

## Requirements
- R1: A command of kind 0 (index) produces one frame of 24 clock pulses carrying start byte 0x70 and then the 16-bit word, high byte first, each byte most significant bit first.
- R2: Kinds 1 and 3 (data) produce one 24-pulse frame carrying start byte 0x72 and then the 16-bit word, high byte first.
- R3: Each bit starts with a falling clock, and the data line changes only then. The data line is stable while the clock is high and select is low, so the receiver samples on the rising clock.
- R4: The low and high clock phases each last H cycles. H is the larger of cfg_half and MIN_HALF, taken when the first command of a frame is accepted, so changes to cfg_half during a frame have no effect.
- R5: Select falls in the first cycle of the first low clock phase and rises right after the last high phase of the frame. The clock is high whenever select is high.
- R6: After reset, and whenever no frame is in progress, select, clock and data are high, busy is low and cmd_ready is high.
- R7: A command of kind 2 (pixel) with last low opens a burst: 0x72 is sent once, then one 16-bit word per accepted command, with select held low. In an open burst the kind of later commands is ignored, and a command with last high ends the frame after its word.
- R8: After select rises, it stays high for at least H cycles before it can fall again, and cmd_ready is low while it rises.
- R9: Busy is high from the cycle after acceptance until the guard gap ends. While busy, cmd_ready is low, except inside an open burst while the block waits for its next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_half | input | DIV_W | Requested half-bit period in clock cycles |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted on this edge when valid |
| cmd_kind | input | 2 | 0 index, 1 or 3 data, 2 pixel burst |
| cmd_word | input | 16 | Index, value or pixel word |
| cmd_last | input | 1 | Closes a pixel burst after this word |
| busy | output | 1 | Frame or guard gap in progress |
| lcd_cs_n | output | 1 | Active-low panel select |
| lcd_sclk | output | 1 | Serial clock, idles high |
| lcd_sdo | output | 1 | Serial data, idles high |

## Verification
The bench builds the block with MIN_HALF set to 2 and DIV_W left at 8. This keeps each half-bit down to a handful of cycles, so full frames, a three-word burst and several back-to-back frames all fit in a short run. The low floor also makes the clamp visible: a cfg_half of 0 must still give 2-cycle phases, while 3 and 5 are used as given. A latching test changes cfg_half in the middle of a frame and checks that the measured phase widths do not move.

// File: rtl/panel_wr_pkg.sv
// Shared constants and types of the serial panel register writer.
package panel_wr_pkg;
    localparam int START_W = 8;
    localparam int WORD_W  = 16;
    localparam int FRAME_W = START_W + WORD_W;
    localparam int BITS_W  = $clog2(FRAME_W + 1);

    localparam logic [START_W-1:0] START_INDEX = 8'h70;
    localparam logic [START_W-1:0] START_DATA  = 8'h72;

    typedef enum logic [1:0] {
        KIND_INDEX = 2'd0,
        KIND_DATA  = 2'd1,
        KIND_PIXEL = 2'd2,
        KIND_DATA2 = 2'd3
    } cmd_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LO   = 3'd1,
        ST_HI   = 3'd2,
        ST_WAIT = 3'd3,
        ST_GAP  = 3'd4
    } wr_state_e;
endpackage

// File: rtl/panel_wr_pace.sv
// Half-bit pacing timer.
// Latches the clamped half period on load. While run is high it pulses tick
// once every half_q cycles. Assumes MIN_HALF >= 1 and MIN_HALF < 2**DIV_W.
module panel_wr_pace #(
    parameter int DIV_W    = 8,
    parameter int MIN_HALF = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] cfg_half,
    input  logic             run,
    output logic             tick
);
    localparam logic [DIV_W-1:0] FLOOR = DIV_W'(MIN_HALF);

    logic [DIV_W-1:0] half_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] eff_half;

    // Apply the build-time floor to the requested period.
    always_comb eff_half = (cfg_half < FLOOR) ? FLOOR : cfg_half;

    // Hold the period for the whole frame.
    always_ff @(posedge clk) begin
        if (!rst_n)     half_q <= FLOOR;
        else if (load)  half_q <= eff_half;
    end

    // Count cycles within the current half-bit phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (tick)      cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    // Mark the last cycle of a phase.
    always_comb tick = run && (cnt_q == half_q - 1'b1);

    a_r4_half_floor: assert property (@(posedge clk) disable iff (!rst_n)
        half_q >= FLOOR);
    a_r4_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < half_q));
endmodule

// File: rtl/panel_wr_shift.sv
// Frame shift register.
// Loads a start byte plus word, or a word alone (burst continuation), and
// shifts left on request. The serial bit is the register's top bit.
module panel_wr_shift
    import panel_wr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_full,
    input  logic               load_word,
    input  logic [START_W-1:0] start_byte,
    input  logic [WORD_W-1:0]  word,
    input  logic               shift,
    output logic               msb
);
    logic [FRAME_W-1:0] sr_q;

    // Load or advance the outgoing bits, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)         sr_q <= '1;
        else if (load_full) sr_q <= {start_byte, word};
        else if (load_word) sr_q <= {word, {START_W{1'b0}}};
        else if (shift)     sr_q <= {sr_q[FRAME_W-2:0], 1'b0};
    end

    always_comb msb = sr_q[FRAME_W-1];
endmodule

// File: rtl/panel_wr_ctrl.sv
// Frame sequencer.
// Walks idle -> low/high bit phases -> burst wait or guard gap -> idle.
// Decodes the line levels from its state. Assumes tick comes from a timer
// that runs in the low, high and gap states.
module panel_wr_ctrl
    import panel_wr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_kind,
    input  logic               cmd_last,
    input  logic               tick,
    input  logic               msb,
    output logic               cmd_ready,
    output logic               busy,
    output logic               load_full,
    output logic               load_word,
    output logic               shift,
    output logic               run,
    output logic [START_W-1:0] start_byte,
    output logic               lcd_cs_n,
    output logic               lcd_sclk,
    output logic               lcd_sdo
);
    wr_state_e         state_q;
    logic [BITS_W-1:0] bits_q;
    logic              burst_q;
    logic              accept;
    logic              last_bit;

    // Decode the handshake and per-phase control.
    always_comb begin
        cmd_ready  = (state_q == ST_IDLE) || (state_q == ST_WAIT);
        accept     = cmd_valid && cmd_ready;
        last_bit   = (bits_q == BITS_W'(1));
        load_full  = accept && (state_q == ST_IDLE);
        load_word  = accept && (state_q == ST_WAIT);
        shift      = (state_q == ST_HI) && tick && !last_bit;
        run        = (state_q == ST_LO) || (state_q == ST_HI) || (state_q == ST_GAP);
        start_byte = (cmd_kind == KIND_INDEX) ? START_INDEX : START_DATA;
    end

    // Decode the line levels from the state.
    always_comb begin
        busy     = (state_q != ST_IDLE);
        lcd_cs_n = (state_q == ST_IDLE) || (state_q == ST_GAP);
        lcd_sclk = (state_q != ST_LO);
        lcd_sdo  = lcd_cs_n ? 1'b1 : msb;
    end

    // Advance the frame state, bit budget and burst flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bits_q  <= '0;
            burst_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    state_q <= ST_LO;
                    bits_q  <= BITS_W'(FRAME_W);
                    burst_q <= (cmd_kind == KIND_PIXEL) && !cmd_last;
                end
                ST_LO: if (tick) state_q <= ST_HI;
                ST_HI: if (tick) begin
                    bits_q <= bits_q - 1'b1;
                    if (last_bit) state_q <= burst_q ? ST_WAIT : ST_GAP;
                    else          state_q <= ST_LO;
                end
                ST_WAIT: if (accept) begin
                    state_q <= ST_LO;
                    bits_q  <= BITS_W'(WORD_W);
                    burst_q <= !cmd_last;
                end
                ST_GAP: if (tick) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    a_r3_sdo_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_cs_n && !$past(lcd_cs_n) && lcd_sclk && $past(lcd_sclk)) |-> $stable(lcd_sdo));
    a_r5_clock_high_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_cs_n |-> lcd_sclk);
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> busy);
    a_r8_no_accept_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_cs_n) |-> !cmd_ready);
    a_r1_bit_budget: assert property (@(posedge clk) disable iff (!rst_n)
        bits_q <= BITS_W'(FRAME_W));
endmodule

// File: rtl/panel_wr_engine.sv
// Serial panel register writer, top level.
// Joins the sequencer, the frame shift register and the half-bit timer.
// Assumes cmd_kind, cmd_word and cmd_last stay stable while cmd_valid is
// high and cmd_ready is low.
module panel_wr_engine
    import panel_wr_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int MIN_HALF = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_half,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [1:0]       cmd_kind,
    input  logic [15:0]      cmd_word,
    input  logic             cmd_last,
    output logic             busy,
    output logic             lcd_cs_n,
    output logic             lcd_sclk,
    output logic             lcd_sdo
);
    logic               load_full;
    logic               load_word;
    logic               shift;
    logic               run;
    logic               tick;
    logic               msb;
    logic [START_W-1:0] start_byte;

    panel_wr_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_kind   (cmd_kind),
        .cmd_last   (cmd_last),
        .tick       (tick),
        .msb        (msb),
        .cmd_ready  (cmd_ready),
        .busy       (busy),
        .load_full  (load_full),
        .load_word  (load_word),
        .shift      (shift),
        .run        (run),
        .start_byte (start_byte),
        .lcd_cs_n   (lcd_cs_n),
        .lcd_sclk   (lcd_sclk),
        .lcd_sdo    (lcd_sdo)
    );

    panel_wr_shift u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_full  (load_full),
        .load_word  (load_word),
        .start_byte (start_byte),
        .word       (cmd_word),
        .shift      (shift),
        .msb        (msb)
    );

    panel_wr_pace #(
        .DIV_W    (DIV_W),
        .MIN_HALF (MIN_HALF)
    ) u_pace (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_full),
        .cfg_half (cfg_half),
        .run      (run),
        .tick     (tick)
    );
endmodule

// File: tb/panel_wr_engine_tb.sv
module panel_wr_engine_tb;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] cfg_half = 8'd2;
    logic             cmd_valid = 1'b0;
    logic             cmd_ready;
    logic [1:0]       cmd_kind = 2'd0;
    logic [15:0]      cmd_word = 16'h0;
    logic             cmd_last = 1'b0;
    logic             busy;
    logic             lcd_cs_n;
    logic             lcd_sclk;
    logic             lcd_sdo;

    panel_wr_engine #(.DIV_W(DIV_W), .MIN_HALF(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
        .cmd_word(cmd_word), .cmd_last(cmd_last), .busy(busy),
        .lcd_cs_n(lcd_cs_n), .lcd_sclk(lcd_sclk), .lcd_sdo(lcd_sdo)
    );

    always #5 clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // Receiver model, sampled on the falling clock edge.
    logic [63:0] cap = '0;
    int ncap = 0, frames = 0, last_n = 0;
    logic [63:0] last_frame = '0;
    int lo_run = 0, hi_run = 0, gap_run = 0;
    int lo_last = 0, hi_last = 0, gap_last = 0, sdo_viol = 0;
    logic p_cs = 1'b1, p_sclk = 1'b1, p_sdo = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!lcd_cs_n && lcd_sclk && !p_sclk) begin
                cap = {cap[62:0], lcd_sdo};
                ncap++;
                lo_last = lo_run;
            end
            if (!lcd_cs_n && !p_cs && !lcd_sclk && p_sclk) hi_last = hi_run;
            if (!lcd_cs_n && !p_cs && lcd_sclk && p_sclk && lcd_sdo !== p_sdo) sdo_viol++;
            if (lcd_cs_n && !p_cs) begin
                frames++; last_frame = cap; last_n = ncap; cap = '0; ncap = 0;
            end
            if (!lcd_cs_n && p_cs) gap_last = gap_run;
            lo_run  = lcd_sclk ? 0 : lo_run + 1;
            hi_run  = (lcd_sclk && !lcd_cs_n) ? hi_run + 1 : 0;
            gap_run = lcd_cs_n ? gap_run + 1 : 0;
        end
        p_cs = lcd_cs_n; p_sclk = lcd_sclk; p_sdo = lcd_sdo;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Offer one command and return in the cycle after it is accepted.
    task automatic send(input logic [1:0] k, input logic [15:0] w, input logic l);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = k; cmd_word = w; cmd_last = l;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // {kind, word, expected 24-bit frame}
    localparam logic [41:0] VEC [6] = '{
        {2'd0, 16'h0022, 24'h700022},
        {2'd1, 16'h1098, 24'h721098},
        {2'd0, 16'h0000, 24'h700000},
        {2'd1, 16'hFFFF, 24'h72FFFF},
        {2'd3, 16'h8001, 24'h728001},
        {2'd0, 16'hA5C3, 24'h70A5C3}
    };

    initial begin
        int f0;
        repeat (3) @(negedge clk);
        // R6: reset state
        chk("R6 reset cs", 64'(lcd_cs_n), 64'd1);
        chk("R6 reset sclk", 64'(lcd_sclk), 64'd1);
        chk("R6 reset sdo", 64'(lcd_sdo), 64'd1);
        chk("R6 reset busy", 64'(busy), 64'd0);
        chk("R6 reset ready", 64'(cmd_ready), 64'd1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1, R2: table of single frames
        for (int i = 0; i < 6; i++) begin
            send(VEC[i][41:40], VEC[i][39:24], 1'b0);
            wait_idle();
            chk(VEC[i][41:40] == 2'd0 ? "R1 index frame" : "R2 data frame",
                last_frame[23:0], 64'(VEC[i][23:0]));
            chk("R1 pulse count", 64'(last_n), 64'd24);
        end
        // R6: idle levels after a frame
        chk("R6 idle lines", {61'd0, lcd_cs_n, lcd_sclk, lcd_sdo}, 64'd7);
        // R3: data never moved while clock high
        chk("R3 sdo stable while high", 64'(sdo_viol), 64'd0);

        // R4, R5, R9: half period, latching, select and busy timing
        cfg_half = 8'd5;
        send(2'd1, 16'h0133, 1'b0);
        chk("R5 cs low after accept", 64'(lcd_cs_n), 64'd0);
        chk("R9 busy after accept", 64'(busy), 64'd1);
        chk("R9 ready low while busy", 64'(cmd_ready), 64'd0);
        cfg_half = 8'd7;
        f0 = frames;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = 2'd0; cmd_word = 16'hDEAD; cmd_last = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (cmd_ready) chk("R9 ready during frame", 64'(cmd_ready), 64'd0);
        end
        cmd_valid = 1'b0;
        wait_idle();
        chk("R9 one frame only", 64'(frames - f0), 64'd1);
        chk("R4 low phase latched", 64'(lo_last), 64'd5);
        chk("R4 high phase latched", 64'(hi_last), 64'd5);
        chk("R2 frame with latched H", last_frame[23:0], 64'h720133);

        // R4: clamp to floor
        cfg_half = 8'd0;
        send(2'd0, 16'h0007, 1'b0);
        wait_idle();
        chk("R4 clamp low phase", 64'(lo_last), 64'd2);
        chk("R4 clamp high phase", 64'(hi_last), 64'd2);

        // R8: back-to-back frames keep a gap
        cfg_half = 8'd3;
        send(2'd0, 16'h0010, 1'b0);
        send(2'd1, 16'h1190, 1'b0);
        chk("R8 gap at least H", 64'(gap_last >= 3), 64'd1);
        wait_idle();
        chk("R2 second frame", last_frame[23:0], 64'h721190);

        // R7: pixel burst with a non-pixel kind inside it
        cfg_half = 8'd2;
        f0 = frames;
        send(2'd2, 16'h1234, 1'b0);
        repeat (120) @(negedge clk);
        chk("R7 burst holds select", 64'(lcd_cs_n), 64'd0);
        chk("R7 clock high while waiting", 64'(lcd_sclk), 64'd1);
        chk("R9 busy while waiting", 64'(busy), 64'd1);
        chk("R9 ready in open burst", 64'(cmd_ready), 64'd1);
        send(2'd0, 16'hABCD, 1'b0);
        send(2'd2, 16'h5555, 1'b1);
        wait_idle();
        chk("R7 burst single frame", 64'(frames - f0), 64'd1);
        chk("R7 burst pulse count", 64'(last_n), 64'd56);
        chk("R7 burst content", last_frame[55:0], 64'h72_1234_ABCD_5555);
        chk("R3 sdo stable end", 64'(sdo_viol), 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog all actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule